// File: doc/BRIEF.md
# Multi-Rate One-Bit Audio Stream Receiver

This block takes eight one-bit oversampled audio streams, four left and four right, that all share one bit clock. It runs on the system clock and treats the bit clock as a slow input signal. It synchronizes that clock and the data lines, and it picks the sampling edge from a polarity setting: the sampling edge is always the opposite of the edge on which the source changes its data. The block shifts each channel's bits into a parallel word, first bit at the MSB, so that downstream decimation or filter logic can take whole words.

A two-bit rate field gives the oversampling ratio against the base sample rate: 64, 128 or 256 bits per base sample. The block raises a frame tick when the last word of each base-sample period completes. Writing a new rate discards any partly filled words and restarts the word and frame counting. Each channel also has a run detector. It flags a channel whose most recent bits all share one value, which means the stream is pinned at positive or negative full scale.

Top module: `dsd_rx`

## Requirements
- R1: While reset is held and after it is released, with no bit sampled yet, `word_vld_o`, `fs_tick_o`, `full_scale_o` and `word_o` are all zero.
- R2: With `launch_rise_i` = 0 the source changes data after the falling bit-clock edge, and bits are sampled on the rising edge. With `launch_rise_i` = 1 bits are sampled on the falling edge.
- R3: Bits are packed MSB first. The first bit sampled after a restart lands in bit WORD_W-1 of the word. `word_vld_o` is a single-cycle pulse that rises on the third rising system-clock edge after the sampling edge of every WORD_W-th bit. It is never high two cycles in a row.
- R4: Channel c occupies `word_o[c*WORD_W +: WORD_W]`. Channels 0..NUM_PAIRS-1 are the left inputs in index order, and channels NUM_PAIRS..2*NUM_PAIRS-1 are the right inputs in index order.
- R5: Rate code 00 means 64 bits per base sample, 01 means 128 and 10 means 256. `fs_tick_o` is high together with `word_vld_o` on the last word of each base sample, so it falls on every (bits per base sample / WORD_W)-th word, and it is never high without `word_vld_o`.
- R6: Rate code 11 is reserved. While it is selected no bit is taken: no word, no tick, and no change in `full_scale_o`.
- R7: A change of `rate_sel_i` drops the partial word in every channel and restarts the word-per-base-sample count. A bit whose sampling falls in the cycle of the change is discarded, and no word completes in the cycle that follows the change.
- R8: `full_scale_o[c]` rises when the last RUN_LEN bits sampled on channel c are all ones or all zeros, and not before. It changes only after a sampled bit.
- R9: `full_scale_o[c]` clears on the first sampled bit that differs from the run.
- R10: Each channel's run detector is independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Shared bit clock of the streams |
| dsd_left_i | input | NUM_PAIRS | Left-channel bit inputs |
| dsd_right_i | input | NUM_PAIRS | Right-channel bit inputs |
| launch_rise_i | input | 1 | 1: source launches data on rising edge; 0: on falling edge |
| rate_sel_i | input | 2 | Oversampling ratio code (00/01/10; 11 reserved) |
| word_o | output | 2*NUM_PAIRS*WORD_W | Packed words, channel c at slice c |
| word_vld_o | output | 1 | One-cycle strobe: all channel words updated |
| fs_tick_o | output | 1 | Last word of a base-sample period |
| full_scale_o | output | 2*NUM_PAIRS | Per-channel sustained full-scale flag |

## Verification
Every result comes out exactly three rising system-clock edges after the bit clock reaches its sampling edge: two edges in the synchronizer and one in the packing or run-count register. The bench changes the bit clock only on falling system-clock edges and waits whole falling edges before it looks. It checks that a word strobe is still low after the second rising edge and high after the third. Word contents, frame ticks and full-scale flags are all read four falling edges after the sampling edge, so each one has settled and the next bit has not yet been sampled. The bench changes the source data half-way through the launch-level phase, so a receiver that samples on the launch edge would capture the previous bit.

// File: rtl/dsd_rx_pkg.sv
package dsd_rx_pkg;
  typedef enum logic [1:0] {
    RATE_X64  = 2'b00,
    RATE_X128 = 2'b01,
    RATE_X256 = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  localparam int BASE_BITS = 64;
endpackage

// File: rtl/dsd_rx_edge.sv
// Synchronizes the bit clock and data into the system clock domain and
// produces a one-cycle strobe on the sampling edge.
module dsd_rx_edge #(
  parameter int NCH  = 8,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dclk_i,
  input  logic [NCH-1:0] data_i,
  input  logic           launch_rise_i,
  output logic           smp_o,
  output logic [NCH-1:0] bits_o
);
  logic [SYNC-1:0] ck_pipe;
  logic [NCH-1:0]  d_pipe [SYNC];
  logic [SYNC:0]   arm;
  logic            ck_prev;
  logic            ck_s;

  assign ck_s = ck_pipe[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_pipe <= '0;
      ck_prev <= 1'b0;
      arm     <= '0;
      for (int s = 0; s < SYNC; s++) d_pipe[s] <= '0;
    end else begin
      ck_pipe <= {ck_pipe[SYNC-2:0], dclk_i};
      d_pipe[0] <= data_i;
      for (int s = 1; s < SYNC; s++) d_pipe[s] <= d_pipe[s-1];
      ck_prev <= ck_s;
      arm     <= {arm[SYNC-1:0], 1'b1};
    end
  end

  // Sample on the edge opposite the launch edge.
  always_comb begin
    if (!arm[SYNC])         smp_o = 1'b0;
    else if (launch_rise_i) smp_o = ck_prev & ~ck_s;
    else                    smp_o = ck_s & ~ck_prev;
  end

  assign bits_o = d_pipe[SYNC-1];
endmodule

// File: rtl/dsd_rx_pack.sv
// Shared bit/word counters with per-channel MSB-first shift registers.
module dsd_rx_pack #(
  parameter int NCH = 8,
  parameter int W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  logic             flush_i,
  input  logic [1:0]       rate_i,
  input  logic [NCH-1:0]   bits_i,
  output logic [NCH*W-1:0] word_o,
  output logic             vld_o,
  output logic             tick_o
);
  import dsd_rx_pkg::*;

  localparam int BASE_WORDS = BASE_BITS / W;
  localparam int BW         = $clog2(W);
  localparam int WC_W       = $clog2(4 * BASE_WORDS);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic [BW-1:0]   bit_cnt;
  logic [WC_W-1:0] word_cnt;
  logic [WC_W-1:0] words_last;
  logic            word_done;

  always_comb begin
    case (rate_i)
      RATE_X64:  words_last = WC_W'(BASE_WORDS - 1);
      RATE_X128: words_last = WC_W'(2 * BASE_WORDS - 1);
      default:   words_last = WC_W'(4 * BASE_WORDS - 1);
    endcase
  end

  assign word_done = smp_i && !flush_i && (bit_cnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      vld_o    <= 1'b0;
      tick_o   <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      tick_o <= 1'b0;
      if (flush_i) begin
        bit_cnt  <= '0;
        word_cnt <= '0;
      end else if (smp_i) begin
        bit_cnt <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
        if (word_done) begin
          vld_o <= 1'b1;
          if (word_cnt == words_last) begin
            word_cnt <= '0;
            tick_o   <= 1'b1;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-2:0] sr;
    always_ff @(posedge clk) begin
      if (rst) begin
        sr              <= '0;
        word_o[c*W +: W] <= '0;
      end else if (smp_i && !flush_i) begin
        sr <= {sr[W-3:0], bits_i[c]};
        if (word_done) word_o[c*W +: W] <= {sr, bits_i[c]};
      end
    end
  end
endmodule

// File: rtl/dsd_rx_fsdet.sv
// Per-channel saturating run-length counter for full-scale detection.
module dsd_rx_fsdet #(
  parameter int NCH     = 8,
  parameter int RUN_LEN = 2048
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_i,
  input  logic [NCH-1:0] bits_i,
  output logic [NCH-1:0] flag_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  for (genvar c = 0; c < NCH; c++) begin : g_run
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          last_bit;

    always_comb begin
      if (cnt != '0 && bits_i[c] == last_bit)
        cnt_nxt = (cnt == RUN_MAX) ? cnt : cnt + 1'b1;
      else
        cnt_nxt = CW'(1);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt       <= '0;
        last_bit  <= 1'b0;
        flag_o[c] <= 1'b0;
      end else if (smp_i) begin
        cnt       <= cnt_nxt;
        last_bit  <= bits_i[c];
        flag_o[c] <= (cnt_nxt == RUN_MAX);
      end
    end
  end
endmodule

// File: rtl/dsd_rx.sv
module dsd_rx #(
  parameter int NUM_PAIRS   = 4,
  parameter int WORD_W      = 32,
  parameter int RUN_LEN     = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            dclk_i,
  input  logic [NUM_PAIRS-1:0]            dsd_left_i,
  input  logic [NUM_PAIRS-1:0]            dsd_right_i,
  input  logic                            launch_rise_i,
  input  logic [1:0]                      rate_sel_i,
  output logic [2*NUM_PAIRS*WORD_W-1:0]   word_o,
  output logic                            word_vld_o,
  output logic                            fs_tick_o,
  output logic [2*NUM_PAIRS-1:0]          full_scale_o
);
  import dsd_rx_pkg::*;

  localparam int NCH = 2 * NUM_PAIRS;

  logic [1:0]     rate_q;
  logic           rate_chg;
  logic           edge_smp;
  logic           take_bit;
  logic [NCH-1:0] bits_s;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= RATE_X64;
    else     rate_q <= rate_sel_i;
  end

  assign rate_chg = (rate_sel_i != rate_q);
  assign take_bit = edge_smp && !rate_chg && (rate_q != RATE_RSVD);

  dsd_rx_edge #(.NCH(NCH), .SYNC(SYNC_STAGES)) u_edge (
    .clk          (clk),
    .rst          (rst),
    .dclk_i       (dclk_i),
    .data_i       ({dsd_right_i, dsd_left_i}),
    .launch_rise_i(launch_rise_i),
    .smp_o        (edge_smp),
    .bits_o       (bits_s)
  );

  dsd_rx_pack #(.NCH(NCH), .W(WORD_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .smp_i  (take_bit),
    .flush_i(rate_chg),
    .rate_i (rate_q),
    .bits_i (bits_s),
    .word_o (word_o),
    .vld_o  (word_vld_o),
    .tick_o (fs_tick_o)
  );

  dsd_rx_fsdet #(.NCH(NCH), .RUN_LEN(RUN_LEN)) u_fs (
    .clk   (clk),
    .rst   (rst),
    .smp_i (take_bit),
    .bits_i(bits_s),
    .flag_o(full_scale_o)
  );
endmodule

// File: rtl/dsd_rx_chk.sv
module dsd_rx_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     rate_sel_i,
  input logic           take_bit,
  input logic           word_vld_o,
  input logic           fs_tick_o,
  input logic [NCH-1:0] full_scale_o
);
  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  p_vld_needs_bit_r3: assert property (@(posedge clk) disable iff (rst)
    !take_bit |=> !word_vld_o);

  p_tick_on_word_r5: assert property (@(posedge clk) disable iff (rst)
    fs_tick_o |-> word_vld_o);

  p_rsvd_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (rate_sel_i == 2'b11) |=> (!word_vld_o && !fs_tick_o));

  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (rate_sel_i != $past(rate_sel_i)) |=> !word_vld_o);

  p_fs_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !take_bit |=> $stable(full_scale_o));
endmodule

bind dsd_rx dsd_rx_chk #(.NCH(2 * NUM_PAIRS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rate_sel_i  (rate_sel_i),
  .take_bit    (take_bit),
  .word_vld_o  (word_vld_o),
  .fs_tick_o   (fs_tick_o),
  .full_scale_o(full_scale_o)
);

// File: tb/sim_dsd_rx.sv
module sim_dsd_rx;
  localparam int P   = 4;
  localparam int NCH = 2 * P;
  localparam int W   = 8;
  localparam int RL  = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic             dclk;
  logic [P-1:0]     dl, dr;
  logic             pol;
  logic [1:0]       rate;
  logic [NCH*W-1:0] word_o;
  logic             word_vld_o, fs_tick_o;
  logic [NCH-1:0]   full_scale_o;

  int ntests = 0, nfail = 0;
  int nwords, nticks, tick_at;
  logic [W-1:0] got [NCH][64];

  always #10 clk = ~clk;

  dsd_rx #(.NUM_PAIRS(P), .WORD_W(W), .RUN_LEN(RL), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .dclk_i(dclk), .dsd_left_i(dl), .dsd_right_i(dr),
    .launch_rise_i(pol), .rate_sel_i(rate), .word_o(word_o),
    .word_vld_o(word_vld_o), .fs_tick_o(fs_tick_o), .full_scale_o(full_scale_o));

  function automatic logic pat(input int c, input int i);
    return ((i * 7 + c * 3) % 5) < 2;
  endfunction

  function automatic logic [NCH-1:0] patv(input int i);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = pat(c, i);
    return v;
  endfunction

  function automatic logic [W-1:0] pword(input int c, input int k, input int base);
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) v[W-1-b] = pat(c, base + k * W + b);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nwords = 0; nticks = 0; tick_at = -1;
  endtask

  always @(negedge clk) begin
    if (!rst && word_vld_o) begin
      if (nwords < 64)
        for (int c = 0; c < NCH; c++) got[c][nwords] = word_o[c*W +: W];
      nwords++;
      if (fs_tick_o) begin
        nticks++;
        tick_at = nwords;
      end
    end
  end

  // One bit: launch level, data change mid-phase, sampling edge, settle.
  task automatic send(input logic [NCH-1:0] b, input bit lat);
    @(negedge clk); dclk = pol;
    repeat (2) @(negedge clk);
    dl = b[P-1:0]; dr = b[NCH-1:P];
    repeat (2) @(negedge clk);
    dclk = ~pol;
    @(negedge clk);
    @(negedge clk);
    if (lat) chk(word_vld_o == 1'b0, "R3 strobe early", word_vld_o, 0);
    @(negedge clk);
    if (lat) chk(word_vld_o == 1'b1, "R3 strobe third edge", word_vld_o, 1);
    @(negedge clk);
  endtask

  task automatic set_rate(input logic [1:0] r);
    @(negedge clk); rate = r;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [NCH-1:0] v;
    rst = 1'b1; dclk = 1'b0; dl = '0; dr = '0; pol = 1'b0; rate = 2'b00;
    clear_mon();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(word_vld_o == 0 && fs_tick_o == 0, "R1 strobes in reset", {word_vld_o, fs_tick_o}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(full_scale_o == 0, "R1 full-scale after reset", full_scale_o, 0);
    chk(word_o == 0, "R1 words after reset", word_o, 0);

    // R2/R3/R4: rising-edge sampling, rate 64x
    clear_mon();
    for (int i = 0; i < 64; i++) send(patv(i), i == 7);
    chk(nwords == 8, "R3 word count pol0", nwords, 8);
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < NCH; c++)
        chk(got[c][k] == pword(c, k, 0), "R4 word content pol0", got[c][k], pword(c, k, 0));
    chk(nticks == 1 && tick_at == 8, "R5 tick at word 8 (x64)", tick_at, 8);

    // R2: falling-edge sampling
    pol = 1'b1;
    clear_mon();
    for (int i = 0; i < 64; i++) send(patv(100 + i), 1'b0);
    chk(nwords == 8, "R2 word count pol1", nwords, 8);
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < NCH; c++)
        chk(got[c][k] == pword(c, k, 100), "R2 word content pol1", got[c][k], pword(c, k, 100));

    // R5: rate 128x and 256x
    set_rate(2'b01);
    clear_mon();
    for (int i = 0; i < 128; i++) send(patv(200 + i), 1'b0);
    chk(nwords == 16, "R5 words x128", nwords, 16);
    chk(nticks == 1 && tick_at == 16, "R5 tick at word 16 (x128)", tick_at, 16);
    set_rate(2'b10);
    clear_mon();
    for (int i = 0; i < 256; i++) send(patv(400 + i), 1'b0);
    chk(nwords == 32, "R5 words x256", nwords, 32);
    chk(nticks == 1 && tick_at == 32, "R5 tick at word 32 (x256)", tick_at, 32);

    // R6: reserved code takes nothing
    set_rate(2'b11);
    clear_mon();
    for (int i = 0; i < RL + 8; i++) send('1, 1'b0);
    chk(nwords == 0 && nticks == 0, "R6 no words reserved", nwords, 0);
    chk(full_scale_o == 0, "R6 full-scale untouched", full_scale_o, 0);

    // R7: rate change flushes partial word and restarts count
    set_rate(2'b00);
    for (int i = 0; i < 5; i++) send(patv(700 + i), 1'b0);
    set_rate(2'b01);
    clear_mon();
    for (int i = 0; i < 128; i++) send(patv(800 + i), 1'b0);
    for (int c = 0; c < NCH; c++)
      chk(got[c][0] == pword(c, 0, 800), "R7 first word after flush", got[c][0], pword(c, 0, 800));
    chk(nticks == 1 && tick_at == 16, "R7 tick count restarted", tick_at, 16);

    // R8/R9/R10: ch0 ones run, ch1 zeros run, others toggling pattern
    v = patv(900); v[0] = 1'b0; v[1] = 1'b1;
    send(v, 1'b0);
    for (int j = 0; j < RL - 1; j++) begin
      v = patv(901 + j); v[0] = 1'b1; v[1] = 1'b0;
      send(v, 1'b0);
    end
    chk(full_scale_o == 0, "R8 not set before RUN_LEN", full_scale_o, 0);
    v = patv(950); v[0] = 1'b1; v[1] = 1'b0;
    send(v, 1'b0);
    chk(full_scale_o == 8'b0000_0011, "R8 R10 set at RUN_LEN", full_scale_o, 8'b0000_0011);
    v = patv(951); v[0] = 1'b0; v[1] = 1'b0;
    send(v, 1'b0);
    chk(full_scale_o == 8'b0000_0010, "R9 ch0 clears on differing bit", full_scale_o, 8'b0000_0010);
    v = patv(952); v[0] = 1'b0; v[1] = 1'b1;
    send(v, 1'b0);
    chk(full_scale_o == 0, "R9 ch1 clears on differing bit", full_scale_o, 0);

    summary();
    $finish;
  end
endmodule